// File: doc/BRIEF.md
# Interrupt Trigger Store Generator

This block converts one interrupt-source event into exactly one 64-bit write on a simple request/response memory bus. The write is aimed at an interrupt controller. Each event carries a source number and a flag that says whether the event-state bits have already been evaluated upstream. A mode bit in the block's control register chooses how that event is encoded:

- **Notify-port mode.** Every store goes to one fixed notification address, and the payload identifies the source.
- **Address-based mode.** The source number and a page size are folded into the store address, so the write lands directly on the controller's management page for that source. The payload carries no meaning and is zero.

Software programs four things through a small register port: the mode, the notification address, the notification index, and error status. Upstream logic presents events through a valid/ready handshake. Only one store is in flight at a time. A store that the bus answers with an error is dropped and not retried. In that case a sticky flag and the failing address are kept for software.

Top module: `irq_trig_store`

## Requirements
- R1: The register at `cfg_addr` 0 holds the mode in bit 0. When that bit is 1, accepted events use address-based mode; when it is 0, they use notify-port mode. Reading `cfg_addr` 0 returns the mode in bit 0 and zeros elsewhere.
- R2: The notification address register (`cfg_addr` 1) carries a page-size flag in bit 62, which is bit 1 when bits are counted from the most significant end. When the flag is set, the page shift is 16. When it is clear, the page shift is 12.
- R3: In address-based mode, the store address is built as follows. Take the notification address with bit 62 forced to 0. OR in the source number times 2^(shift+1). OR in 2^shift.
- R4: In address-based mode, an event flagged as already checked also ORs the inject offset 0x800 into the address.
- R5: In address-based mode, the store data value is zero.
- R6: In notify-port mode, the store address is the notification address exactly as written, including bit 62. The data value is the notification index (`cfg_addr` 2) ORed with the source number.
- R7: In notify-port mode, an event flagged as checked also sets bit 31 of the data value.
- R8: The data value goes onto `bus_wdata` in big-endian byte order. Its most significant byte is on `bus_wdata[7:0]` and its least significant byte is on `bus_wdata[63:56]`.
- R9: An event is accepted when `evt_valid` and `evt_ready` are both high. `evt_ready` is low from the cycle after acceptance until the bus response has been taken. `bus_req_valid` rises in the cycle after acceptance. It then holds with a stable address and data until `bus_req_ready` is seen.
- R10: A response with `bus_rsp_err` high drops the store. The store is not reissued. The response sets bit 0 of the status register (`cfg_addr` 3) and records the store address in the read-only register at `cfg_addr` 4.
- R11: Writing 1 to status bit 0 clears the sticky error. If an error response arrives in the same cycle as that write, the error wins and the bit stays set.
- R12: After reset, all registers read zero, `evt_ready` is high, and `bus_req_valid` is low.
- R13: Address and data are formed from the configuration at the moment the event is accepted. Register writes made while a store is outstanding do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 64 | Register write data |
| cfg_rdata | output | 64 | Register read data for `cfg_addr` |
| evt_valid | input | 1 | Interrupt event present |
| evt_ready | output | 1 | Block can take an event |
| evt_src | input | SRC_W | Source number of the event |
| evt_checked | input | 1 | State bits already checked upstream |
| bus_req_valid | output | 1 | Store request present |
| bus_req_ready | input | 1 | Bus takes the store request |
| bus_addr | output | 64 | Store target address |
| bus_wdata | output | 64 | Store data, big-endian byte lanes |
| bus_rsp_valid | input | 1 | Store response present |
| bus_rsp_err | input | 1 | Store response reports an error |

## Verification
Some properties are checked by assertions on every cycle:

- the request holding stable while the bus stalls;
- `evt_ready` dropping after an accept;
- no reissue after a response;
- zero data in address-based mode;
- the sticky error setting, and staying set until it is cleared.

The exact address arithmetic, and the choice between page shifts and the inject offset, are checked only by the bench's scenarios. Those scenarios use hand-computed addresses for both page sizes, both check flags and both modes. The same applies to the big-endian lane order and to configuration changes made while a store is in flight. The race between a W1C write and a concurrent error is shown only in a directed bench case.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;

  localparam int PG_FLAG_BIT = 62;

  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_NADDR = 3'd1;
  localparam logic [2:0] REG_NIDX  = 3'd2;
  localparam logic [2:0] REG_STAT  = 3'd3;
  localparam logic [2:0] REG_FAIL  = 3'd4;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP} mst_state_t;

  typedef struct packed {
    logic [63:0] addr;
    logic [63:0] data;
  } store_t;

  function automatic logic [5:0] page_shift(input logic [63:0] naddr);
    return naddr[PG_FLAG_BIT] ? 6'd16 : 6'd12;
  endfunction

  function automatic logic [63:0] abt_addr(input logic [63:0] naddr,
                                           input logic [63:0] src,
                                           input logic        chk,
                                           input logic [63:0] inj);
    logic [5:0]  sh;
    logic [63:0] a;
    sh = page_shift(naddr);
    a  = naddr & ~(64'd1 << PG_FLAG_BIT);
    a  = a | (src << (sh + 6'd1)) | (64'd1 << sh);
    if (chk) a = a | inj;
    return a;
  endfunction

  function automatic logic [63:0] notify_data(input logic [63:0] nidx,
                                              input logic [63:0] src,
                                              input logic        chk,
                                              input logic [63:0] chk_mask);
    logic [63:0] d;
    d = nidx | src;
    if (chk) d = d | chk_mask;
    return d;
  endfunction

  function automatic logic [63:0] bswap64(input logic [63:0] v);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = v[8*(7-k) +: 8];
    return r;
  endfunction

endpackage

// File: rtl/irq_trig_regs.sv
module irq_trig_regs
  import irq_trig_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [63:0] cfg_wdata,
  output logic [63:0] cfg_rdata,
  output logic        mode_abt,
  output logic [63:0] naddr,
  output logic [63:0] nidx,
  input  logic        err_set,
  input  logic [63:0] err_addr
);

  logic        err_sticky;
  logic [63:0] fail_addr;
  logic        w1c_hit;

  assign w1c_hit = cfg_we && (cfg_addr == REG_STAT) && cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_abt <= 1'b0;
      naddr    <= '0;
      nidx     <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        REG_CTRL:  mode_abt <= cfg_wdata[0];
        REG_NADDR: naddr    <= cfg_wdata;
        REG_NIDX:  nidx     <= cfg_wdata;
        default:   ;
      endcase
    end
  end

  // error wins over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_sticky <= 1'b0;
      fail_addr  <= '0;
    end else if (err_set) begin
      err_sticky <= 1'b1;
      fail_addr  <= err_addr;
    end else if (w1c_hit) begin
      err_sticky <= 1'b0;
    end
  end

  always_comb begin
    case (cfg_addr)
      REG_CTRL:  cfg_rdata = {63'd0, mode_abt};
      REG_NADDR: cfg_rdata = naddr;
      REG_NIDX:  cfg_rdata = nidx;
      REG_STAT:  cfg_rdata = {63'd0, err_sticky};
      REG_FAIL:  cfg_rdata = fail_addr;
      default:   cfg_rdata = '0;
    endcase
  end

  assert_err_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> err_sticky);

  assert_sticky_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky && !w1c_hit) |=> err_sticky);

endmodule

// File: rtl/irq_trig_form.sv
module irq_trig_form
  import irq_trig_pkg::*;
#(
  parameter int          SRC_W   = 16,
  parameter logic [63:0] INJ_OFS = 64'h800,
  parameter int          CHK_BIT = 31
)(
  input  logic             mode_abt,
  input  logic [63:0]      naddr,
  input  logic [63:0]      nidx,
  input  logic [SRC_W-1:0] src,
  input  logic             chk,
  output store_t           trig
);

  localparam logic [63:0] CHK_MASK = 64'd1 << CHK_BIT;

  logic [63:0] src64;
  assign src64 = 64'(src);

  always_comb begin
    if (mode_abt) begin
      trig.addr = abt_addr(naddr, src64, chk, INJ_OFS);
      trig.data = '0;
    end else begin
      trig.addr = naddr;
      trig.data = notify_data(nidx, src64, chk, CHK_MASK);
    end
  end

endmodule

// File: rtl/irq_trig_master.sv
module irq_trig_master
  import irq_trig_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        evt_valid,
  output logic        evt_ready,
  input  store_t      next_store,
  output logic        bus_req_valid,
  input  logic        bus_req_ready,
  output logic [63:0] bus_addr,
  output logic [63:0] bus_wdata,
  input  logic        bus_rsp_valid,
  input  logic        bus_rsp_err,
  output logic        err_set,
  output logic [63:0] err_addr
);

  mst_state_t state;
  store_t     held;
  logic       accept, req_fire, rsp_fire;

  assign evt_ready     = (state == ST_IDLE);
  assign bus_req_valid = (state == ST_REQ);
  assign accept        = evt_valid && evt_ready;
  assign req_fire      = bus_req_valid && bus_req_ready;
  assign rsp_fire      = (state == ST_RSP) && bus_rsp_valid;
  assign bus_addr      = held.addr;
  assign bus_wdata     = bswap64(held.data);
  assign err_set       = rsp_fire && bus_rsp_err;
  assign err_addr      = held.addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      held  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          held  <= next_store;
          state <= ST_REQ;
        end
        ST_REQ:  if (req_fire) state <= ST_RSP;
        ST_RSP:  if (rsp_fire) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_req_ready) |=>
      (bus_req_valid && $stable(bus_addr) && $stable(bus_wdata)));

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!evt_ready && bus_req_valid));

  assert_no_retry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire |=> !bus_req_valid);

endmodule

// File: rtl/irq_trig_store.sv
module irq_trig_store
  import irq_trig_pkg::*;
#(
  parameter int          SRC_W   = 16,
  parameter logic [63:0] INJ_OFS = 64'h800,
  parameter int          CHK_BIT = 31
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [63:0]      cfg_wdata,
  output logic [63:0]      cfg_rdata,
  input  logic             evt_valid,
  output logic             evt_ready,
  input  logic [SRC_W-1:0] evt_src,
  input  logic             evt_checked,
  output logic             bus_req_valid,
  input  logic             bus_req_ready,
  output logic [63:0]      bus_addr,
  output logic [63:0]      bus_wdata,
  input  logic             bus_rsp_valid,
  input  logic             bus_rsp_err
);

  logic        mode_abt;
  logic [63:0] naddr, nidx, err_addr;
  logic        err_set;
  store_t      next_store;

  irq_trig_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mode_abt(mode_abt), .naddr(naddr), .nidx(nidx),
    .err_set(err_set), .err_addr(err_addr)
  );

  irq_trig_form #(.SRC_W(SRC_W), .INJ_OFS(INJ_OFS), .CHK_BIT(CHK_BIT)) u_form (
    .mode_abt(mode_abt), .naddr(naddr), .nidx(nidx),
    .src(evt_src), .chk(evt_checked), .trig(next_store)
  );

  irq_trig_master u_mst (
    .clk(clk), .rst_n(rst_n),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .next_store(next_store),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_err(bus_rsp_err),
    .err_set(err_set), .err_addr(err_addr)
  );

  assert_abt_zero_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_abt && evt_ready && evt_valid) |=> (bus_wdata == 64'd0));

endmodule

// File: tb/test_irq_trig_store.sv
`timescale 1ns/1ps
module test_irq_trig_store;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic        evt_valid = 1'b0;
  logic        evt_ready;
  logic [15:0] evt_src = '0;
  logic        evt_checked = 1'b0;
  logic        bus_req_valid;
  logic        bus_req_ready = 1'b1;
  logic [63:0] bus_addr, bus_wdata;
  logic        bus_rsp_valid = 1'b0;
  logic        bus_rsp_err = 1'b0;

  always #2.5 clk = ~clk;

  irq_trig_store i_irq_trig_store (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_src(evt_src), .evt_checked(evt_checked),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_err(bus_rsp_err)
  );

  int vectors = 0, miscompares = 0;

  // behavioural reference state
  bit          m_mode, m_sticky, m_abt;
  logic [63:0] m_naddr, m_nidx, m_fail, m_addr, m_data;
  int          m_phase;            // 0 idle, 1 request, 2 waiting for response
  logic [63:0] last_addr, last_wdata;
  int          stall = 0;
  bit          err_next = 1'b0;

  function automatic logic [63:0] ref_addr(logic [63:0] na, logic [63:0] s, bit c, bit abt);
    logic [63:0] pg;
    if (!abt) return na;
    pg = na[62] ? 64'd65536 : 64'd4096;
    return (na & ~(64'd1 << 62)) | (s * pg * 2) | pg | (c ? 64'h800 : 64'd0);
  endfunction

  function automatic logic [63:0] ref_data(logic [63:0] idx, logic [63:0] s, bit c, bit abt);
    if (abt) return 64'd0;
    return idx | s | (c ? 64'h8000_0000 : 64'd0);
  endfunction

  function automatic logic [63:0] be_lanes(logic [63:0] v);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[63 - 8*k -: 8] = v[8*k +: 8];
    return r;
  endfunction

  function automatic logic [63:0] ref_read(logic [2:0] a);
    case (a)
      3'd0: return {63'd0, m_mode};
      3'd1: return m_naddr;
      3'd2: return m_nidx;
      3'd3: return {63'd0, m_sticky};
      3'd4: return m_fail;
      default: return 64'd0;
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit set_err;
    set_err = 1'b0;
    if (!rst_n) begin
      m_mode = 0; m_sticky = 0; m_abt = 0; m_naddr = '0; m_nidx = '0;
      m_fail = '0; m_addr = '0; m_data = '0; m_phase = 0;
      return;
    end
    if (m_phase == 0 && evt_valid) begin
      m_addr  = ref_addr(m_naddr, 64'(evt_src), evt_checked, m_mode);
      m_data  = ref_data(m_nidx, 64'(evt_src), evt_checked, m_mode);
      m_abt   = m_mode;
      m_phase = 1;
    end else if (m_phase == 1 && bus_req_ready) begin
      m_phase = 2;
    end else if (m_phase == 2 && bus_rsp_valid) begin
      set_err = bus_rsp_err;
      m_phase = 0;
    end
    if (cfg_we) begin
      case (cfg_addr)
        3'd0: m_mode  = cfg_wdata[0];
        3'd1: m_naddr = cfg_wdata;
        3'd2: m_nidx  = cfg_wdata;
        3'd3: if (cfg_wdata[0]) m_sticky = 1'b0;
        default: ;
      endcase
    end
    if (set_err) begin
      m_sticky = 1'b1;
      m_fail   = m_addr;
    end
  endtask

  task automatic compare();
    check(evt_ready === (m_phase == 0), "R9 evt_ready", 64'(evt_ready), 64'(m_phase == 0));
    check(bus_req_valid === (m_phase == 1), "R9 bus_req_valid", 64'(bus_req_valid), 64'(m_phase == 1));
    if (m_phase == 1) begin
      check(bus_addr === m_addr, m_abt ? "R3 address" : "R6 address", bus_addr, m_addr);
      check(bus_wdata === be_lanes(m_data), "R8 data lanes", bus_wdata, be_lanes(m_data));
      last_addr  = bus_addr;
      last_wdata = bus_wdata;
    end
    check(cfg_rdata === ref_read(cfg_addr), "R10 register read", cfg_rdata, ref_read(cfg_addr));
  endtask

  task automatic respond();
    bus_req_ready = !(m_phase == 1 && stall > 0);
    if (m_phase == 1 && stall > 0) stall--;
    bus_rsp_valid = (m_phase == 2);
    bus_rsp_err   = (m_phase == 2) && err_next;
  endtask

  task automatic tick();
    @(negedge clk);
    model_step();
    compare();
    respond();
  endtask

  task automatic wr(logic [2:0] a, logic [63:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a);
    cfg_addr = a;
    tick();
  endtask

  task automatic fire(logic [15:0] s, bit c, bit e, int st);
    err_next = e; stall = st;
    evt_valid = 1'b1; evt_src = s; evt_checked = c;
    tick();
    evt_valid = 1'b0;
    for (int i = 0; i < 30 && m_phase != 0; i++) tick();
    err_next = 1'b0;
  endtask

  initial begin
    #1000000;
    miscompares++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a));
      check(cfg_rdata === 64'd0, "R12 reset register", cfg_rdata, 64'd0);
    end
    check(evt_ready === 1'b1 && bus_req_valid === 1'b0, "R12 reset handshake",
          {bus_req_valid, evt_ready}, 64'd1);

    // notify-port mode
    wr(3'd1, 64'h0000_0060_3000_0000);
    wr(3'd2, 64'h0000_0000_0000_1000);
    fire(16'd5, 1'b0, 1'b0, 0);
    check(last_addr === 64'h0000_0060_3000_0000, "R6 notify address", last_addr, 64'h0000_0060_3000_0000);
    check(last_wdata === 64'h0510_0000_0000_0000, "R6 notify data", last_wdata, 64'h0510_0000_0000_0000);
    fire(16'd5, 1'b1, 1'b0, 0);
    check(last_wdata === 64'h0510_0080_0000_0000, "R7 checked flag", last_wdata, 64'h0510_0080_0000_0000);
    check(last_wdata[63:56] === 8'h05, "R8 low byte in top lane", 64'(last_wdata[63:56]), 64'h05);
    wr(3'd1, 64'h4000_0000_0000_2000);
    fire(16'd9, 1'b0, 1'b0, 0);
    check(last_addr === 64'h4000_0000_0000_2000, "R6 flag kept", last_addr, 64'h4000_0000_0000_2000);

    // address-based mode
    wr(3'd0, 64'd1);
    rd(3'd0);
    check(cfg_rdata === 64'd1, "R1 mode readback", cfg_rdata, 64'd1);
    wr(3'd1, 64'h0000_0060_0000_0000);
    fire(16'd3, 1'b0, 1'b0, 0);
    check(last_addr === 64'h0000_0060_0000_7000, "R3 4K page", last_addr, 64'h0000_0060_0000_7000);
    check(last_wdata === 64'd0, "R5 zero data", last_wdata, 64'd0);
    fire(16'd3, 1'b1, 1'b0, 0);
    check(last_addr === 64'h0000_0060_0000_7800, "R4 inject offset", last_addr, 64'h0000_0060_0000_7800);
    wr(3'd1, 64'h4000_0060_0000_0000);
    fire(16'h12, 1'b1, 1'b0, 0);
    check(last_addr === 64'h0000_0060_0025_0800, "R2 64K page", last_addr, 64'h0000_0060_0025_0800);

    // stall with a configuration change in flight
    wr(3'd1, 64'h0000_0060_0000_0000);
    err_next = 1'b0; stall = 3;
    evt_valid = 1'b1; evt_src = 16'd1; evt_checked = 1'b0;
    tick();
    evt_valid = 1'b0;
    wr(3'd1, 64'd0);
    wr(3'd0, 64'd0);
    check(bus_req_valid === 1'b1 && bus_addr === 64'h0000_0060_0000_3000, "R13 held address",
          bus_addr, 64'h0000_0060_0000_3000);
    for (int i = 0; i < 30 && m_phase != 0; i++) tick();

    // error path
    wr(3'd1, 64'h0000_0060_3000_0000);
    fire(16'd2, 1'b0, 1'b1, 0);
    tick(); tick();
    check(bus_req_valid === 1'b0, "R10 no retry", 64'(bus_req_valid), 64'd0);
    rd(3'd3);
    check(cfg_rdata === 64'd1, "R10 sticky set", cfg_rdata, 64'd1);
    rd(3'd4);
    check(cfg_rdata === 64'h0000_0060_3000_0000, "R10 failing address", cfg_rdata, 64'h0000_0060_3000_0000);
    wr(3'd3, 64'd1);
    rd(3'd3);
    check(cfg_rdata === 64'd0, "R11 clear", cfg_rdata, 64'd0);

    // clear racing a new error
    err_next = 1'b1; stall = 0;
    evt_valid = 1'b1; evt_src = 16'd4; evt_checked = 1'b0;
    tick();
    evt_valid = 1'b0;
    for (int i = 0; i < 30 && m_phase != 2; i++) tick();
    cfg_we = 1'b1; cfg_addr = 3'd3; cfg_wdata = 64'd1;
    tick();
    cfg_we = 1'b0;
    err_next = 1'b0;
    rd(3'd3);
    check(cfg_rdata === 64'd1, "R11 error wins", cfg_rdata, 64'd1);

    repeat (3) tick();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule